// File: doc/BRIEF.md
# Memory-Mapped Packet Mailbox

This block sits between a processor bus and a network-side agent and moves whole packets one byte at a time through a small register window. The processor side is a plain 32-bit slave port. It has a 6-bit byte address, a write strobe with write data, and a read strobe. Read data is registered and comes back one cycle after the strobe. The network side has two byte streams, each with a valid/ready handshake and an end-of-frame marker. An internal byte buffer backs each stream.

When a frame arrives, the block stores its bytes and loads a receive count with the frame length. It then raises a receive-available flag. Software drains the frame by reading the receive data window once per byte, and the count falls to zero as it does. To send, software writes a byte count and then writes that many bytes into the transmit data window. The block then streams the frame out, clears the count and raises a transmit-done flag.

An interrupt control register collects the two flags and a self-clearing test bit. Their OR drives the interrupt output. A pending receive flag holds off the next incoming frame. The window also holds a constant 64-bit identifier, a busy bit and a constant information word.

Top module: `pkt_mailbox`

## Requirements
- R1: Register map by byte address. Identifier low word at 0x00, identifier high word at 0x04, busy at 0x08, receive count at 0x0C, transmit count at 0x10, interrupt control at 0x14, info word at 0x18, receive data at 0x1C, transmit data at 0x20. The default identifier is the ASCII text "PKTMBOX1" with 'P' in bits 7:0 and each later character one byte higher, so the low word is 0x4D544B50 and the high word is 0x31584F42. The info word reads the INFO_WORD parameter and ignores writes. Any other offset, and any unused bit, reads 0. Read data appears on bus_rdata one cycle after the read strobe.
- R2: Bit 0 of the busy register reads 1 from the first accepted byte of a receive frame until its last byte, and while a transmit frame is being streamed out. Otherwise it reads 0.
- R3: rx_ready is 1 only while interrupt control bit 1 is clear and the receive count is 0. When the byte marked rx_last is accepted, the receive count takes the frame length and bit 1 is set.
- R4: Each read of receive data returns the next byte of the frame, first byte first, in bits 7:0 with bits 31:8 at 0, and lowers the receive count by one. A read at count 0 returns 0 and leaves the count at 0.
- R5: Bytes of a receive frame beyond DEPTH are discarded, and the receive count then saturates at DEPTH.
- R6: A transmit count write is clamped to DEPTH and is ignored while a frame is streaming out. Transmit data writes store bits 7:0, in order. Once count bytes have been written, the frame streams out on tx_byte with tx_last on its final byte, and tx_byte and tx_last hold while tx_ready is 0. Transmit data writes beyond the count are ignored.
- R7: After the last transmit byte is accepted, the transmit count reads 0 and interrupt control bit 0 is set.
- R8: In interrupt control, bit 0 is transmit done and bit 1 is receive available. Writing 1 to a bit clears only that bit. If a hardware set and a clear write fall in the same cycle, the set wins.
- R9: Writing 1 to interrupt control bit 31 sets a test bit. A read of interrupt control returns it and then clears it. A write of all zeros also clears it.
- R10: irq is the OR of interrupt control bits 0, 1 and 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| rx_valid | input | 1 | Receive byte valid |
| rx_byte | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the final byte of a receive frame |
| rx_ready | output | 1 | Block accepts the receive byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_byte | output | 8 | Transmit byte |
| tx_last | output | 1 | Marks the final byte of a transmit frame |
| tx_ready | input | 1 | Agent accepts the transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH set to 16 and the other parameters at their defaults. With this depth, random receive frames of up to 24 bytes regularly overrun the buffer, so the saturation and discard path is exercised often. A transmit count write of 40 also reaches the clamp. The short frames keep each receive and transmit round trip to a few dozen cycles, which leaves room for many random frames next to the directed checks of the test bit and the set-versus-clear collision.

// File: rtl/pmb_pkg.sv
package pmb_pkg;

    // Word index (byte address bits 5:2) of each register.
    localparam logic [3:0] W_ID_LO  = 4'd0;
    localparam logic [3:0] W_ID_HI  = 4'd1;
    localparam logic [3:0] W_BUSY   = 4'd2;
    localparam logic [3:0] W_RXCNT  = 4'd3;
    localparam logic [3:0] W_TXCNT  = 4'd4;
    localparam logic [3:0] W_INTCTL = 4'd5;
    localparam logic [3:0] W_INFO   = 4'd6;
    localparam logic [3:0] W_RXDAT  = 4'd7;
    localparam logic [3:0] W_TXDAT  = 4'd8;

    // Interrupt control bit positions.
    localparam int IC_TX   = 0;
    localparam int IC_RX   = 1;
    localparam int IC_TEST = 31;

    // Default identifier: "PKTMBOX1", first character in the lowest byte.
    localparam logic [63:0] DEF_DEV_ID = "1XOBMTKP";

    typedef struct packed {
        logic tx_done;
        logic rx_avail;
        logic test;
    } irq_flags_t;

endpackage

// File: rtl/pmb_byte_buf.sv
module pmb_byte_buf #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/pmb_irq.sv
module pmb_irq
    import pmb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_tx,
    input  logic        set_rx,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic        rd_en,
    output irq_flags_t  flags,
    output logic        irq
);

    irq_flags_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        // Clear-by-one first, hardware set afterwards so a set wins.
        if (wr_en && wdata[IC_TX]) f_d.tx_done  = 1'b0;
        if (wr_en && wdata[IC_RX]) f_d.rx_avail = 1'b0;
        if (set_tx)                f_d.tx_done  = 1'b1;
        if (set_rx)                f_d.rx_avail = 1'b1;
        // Test bit: self-clears on read, set by writing 1, cleared by all-zero write.
        if (rd_en)                 f_d.test = 1'b0;
        if (wr_en) begin
            if (wdata[IC_TEST])    f_d.test = 1'b1;
            else if (wdata == '0)  f_d.test = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flags = f_q;
    assign irq   = f_q.tx_done | f_q.rx_avail | f_q.test;

endmodule

// File: rtl/pkt_mailbox.sv
module pkt_mailbox
    import pmb_pkg::*;
#(
    parameter int          DEPTH     = 64,
    parameter int          MAX_COUNT = 65536,
    parameter logic [63:0] DEV_ID    = DEF_DEV_ID,
    parameter logic [31:0] INFO_WORD = 32'h0000_0005
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_last,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        irq
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;
    localparam int CNT_W = $clog2(MAX_COUNT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] rx_cnt;
        logic [PTR_W-1:0] rx_rd;
        logic [PTR_W-1:0] rx_wr;
        logic             rx_act;
        logic [CNT_W-1:0] tx_cnt;
        logic [PTR_W-1:0] tx_wr;
        logic [PTR_W-1:0] tx_rd;
        logic             tx_send;
        logic [31:0]      rdata;
    } state_t;

    state_t     s_d, s_q;
    irq_flags_t flags;
    logic [3:0] word;
    logic       rd_rxdat, wr_txcnt, wr_txdat, wr_ic, rd_ic;
    logic       rx_take, rx_room, rx_done, tx_wr_en, tx_pop, tx_done;
    logic       busy, ic_rx;
    logic [PTR_W-1:0] rx_len;
    logic [7:0] rx_rd_byte, tx_rd_byte;

    assign word     = bus_addr[5:2];
    assign rd_rxdat = bus_rd && (word == W_RXDAT);
    assign rd_ic    = bus_rd && (word == W_INTCTL);
    assign wr_txcnt = bus_wr && (word == W_TXCNT);
    assign wr_txdat = bus_wr && (word == W_TXDAT);
    assign wr_ic    = bus_wr && (word == W_INTCTL);

    assign ic_rx    = flags.rx_avail;
    assign rx_ready = !ic_rx && (s_q.rx_cnt == '0);
    assign rx_take  = rx_valid && rx_ready;
    assign rx_room  = s_q.rx_wr < PTR_W'(DEPTH);
    assign rx_done  = rx_take && rx_last;
    assign rx_len   = rx_room ? s_q.rx_wr + PTR_W'(1) : s_q.rx_wr;

    assign tx_wr_en = wr_txdat && !s_q.tx_send && (CNT_W'(s_q.tx_wr) < s_q.tx_cnt);
    assign tx_valid = s_q.tx_send;
    assign tx_byte  = tx_rd_byte;
    assign tx_last  = s_q.tx_send && ((CNT_W'(s_q.tx_rd) + CNT_W'(1)) == s_q.tx_cnt);
    assign tx_pop   = tx_valid && tx_ready;
    assign tx_done  = tx_pop && tx_last;

    assign busy      = s_q.rx_act | s_q.tx_send;
    assign bus_rdata = s_q.rdata;

    pmb_byte_buf #(.DEPTH(DEPTH)) i_rx_buf (
        .clk   (clk),
        .we    (rx_take && rx_room),
        .waddr (s_q.rx_wr[IDX_W-1:0]),
        .wdata (rx_byte),
        .raddr (s_q.rx_rd[IDX_W-1:0]),
        .rdata (rx_rd_byte)
    );

    pmb_byte_buf #(.DEPTH(DEPTH)) i_tx_buf (
        .clk   (clk),
        .we    (tx_wr_en),
        .waddr (s_q.tx_wr[IDX_W-1:0]),
        .wdata (bus_wdata[7:0]),
        .raddr (s_q.tx_rd[IDX_W-1:0]),
        .rdata (tx_rd_byte)
    );

    pmb_irq i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_tx (tx_done),
        .set_rx (rx_done),
        .wr_en  (wr_ic),
        .wdata  (bus_wdata),
        .rd_en  (rd_ic),
        .flags  (flags),
        .irq    (irq)
    );

    always_comb begin
        s_d = s_q;

        // Receive side: fill buffer, publish length on the last byte.
        if (rx_take) begin
            s_d.rx_act = 1'b1;
            if (rx_room) s_d.rx_wr = s_q.rx_wr + PTR_W'(1);
            if (rx_last) begin
                s_d.rx_cnt = CNT_W'(rx_len);
                s_d.rx_wr  = '0;
                s_d.rx_rd  = '0;
                s_d.rx_act = 1'b0;
            end
        end
        if (rd_rxdat && (s_q.rx_cnt != '0)) begin
            s_d.rx_cnt = s_q.rx_cnt - CNT_W'(1);
            s_d.rx_rd  = s_q.rx_rd + PTR_W'(1);
        end

        // Transmit side: count, fill, stream.
        if (wr_txcnt && !s_q.tx_send) begin
            s_d.tx_cnt = (bus_wdata > 32'(DEPTH)) ? CNT_W'(DEPTH) : CNT_W'(bus_wdata);
            s_d.tx_wr  = '0;
        end
        if (tx_wr_en) begin
            s_d.tx_wr = s_q.tx_wr + PTR_W'(1);
            if ((CNT_W'(s_q.tx_wr) + CNT_W'(1)) == s_q.tx_cnt) begin
                s_d.tx_send = 1'b1;
                s_d.tx_rd   = '0;
            end
        end
        if (tx_pop) begin
            if (tx_last) begin
                s_d.tx_send = 1'b0;
                s_d.tx_cnt  = '0;
                s_d.tx_wr   = '0;
                s_d.tx_rd   = '0;
            end else begin
                s_d.tx_rd = s_q.tx_rd + PTR_W'(1);
            end
        end

        // Registered read data.
        if (bus_rd) begin
            case (word)
                W_ID_LO:  s_d.rdata = DEV_ID[31:0];
                W_ID_HI:  s_d.rdata = DEV_ID[63:32];
                W_BUSY:   s_d.rdata = {31'd0, busy};
                W_RXCNT:  s_d.rdata = 32'(s_q.rx_cnt);
                W_TXCNT:  s_d.rdata = 32'(s_q.tx_cnt);
                W_INTCTL: s_d.rdata = {flags.test, 29'd0, flags.rx_avail, flags.tx_done};
                W_INFO:   s_d.rdata = INFO_WORD;
                W_RXDAT:  s_d.rdata = (s_q.rx_cnt != '0) ? {24'd0, rx_rd_byte} : 32'd0;
                default:  s_d.rdata = 32'd0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/pmb_checker.sv
module pmb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  bus_addr,
    input logic        bus_wr,
    input logic [31:0] bus_wdata,
    input logic        rx_valid,
    input logic        rx_ready,
    input logic        rx_last,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_byte,
    input logic        tx_last,
    input logic        irq,
    input logic        busy,
    input logic        ic_rx
);

    // R6: a stalled transmit byte holds.
    p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte) && $stable(tx_last));

    // R3: completing a receive frame raises the flag and closes the input.
    p_rx_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready && rx_last |=> ic_rx && !rx_ready);

    // R7: the final transmit handshake ends the stream and interrupts.
    p_tx_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last |=> irq && !tx_valid);

    // R9: a test write raises the interrupt.
    p_test_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 6'h14 && bus_wdata[31] |=> irq);

    // R2: mid-frame receive shows busy.
    p_rx_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready && !rx_last |=> busy);

endmodule

bind pkt_mailbox pmb_checker i_pmb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .rx_last   (rx_last),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_byte   (tx_byte),
    .tx_last   (tx_last),
    .irq       (irq),
    .busy      (busy),
    .ic_rx     (ic_rx)
);

// File: tb/test_pkt_mailbox.sv
module test_pkt_mailbox;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_last = 1'b0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_last;
    logic        tx_ready = 1'b0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] frm [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_mailbox #(.DEPTH(DEPTH)) i_pkt_mailbox (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last), .tx_ready(tx_ready),
        .irq(irq)
    );

    function automatic int min_depth(input int n);
        return (n > DEPTH) ? DEPTH : n;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rx_send(input int first, input int n);
        for (int i = first; i < n; i++) begin
            rx_valid = 1'b1; rx_byte = frm[i]; rx_last = (i == n - 1);
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic tx_collect(input int n);
        int   got = 0;
        bit   stalled = 1'b0;
        logic [7:0] held = '0;
        while (got < n) begin
            if (stalled) chk("R6 hold", {24'd0, tx_byte}, {24'd0, held});
            tx_ready = ($urandom % 3) != 0;
            stalled = tx_valid && !tx_ready;
            held = tx_byte;
            if (tx_valid && tx_ready) begin
                chk("R6 tx byte", {24'd0, tx_byte}, {24'd0, frm[got]});
                chk("R6 tx last", {31'd0, tx_last}, {31'd0, got == n - 1});
                got++;
            end
            @(negedge clk);
        end
        tx_ready = 1'b0;
    endtask

    task automatic drain_rx(input int n);
        logic [31:0] v;
        bus_read(6'h0C, v); chk("R3 rx count", v, 32'(n));
        for (int i = 0; i < n; i++) begin
            bus_read(6'h1C, v); chk("R4 rx data", v, {24'd0, frm[i]});
        end
        bus_read(6'h1C, v); chk("R4 empty read", v, 32'd0);
        bus_read(6'h0C, v); chk("R4 count stays 0", v, 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int len;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        bus_read(6'h08, v); chk("R2 reset busy", v, 0);
        bus_read(6'h0C, v); chk("R3 reset rx count", v, 0);
        bus_read(6'h10, v); chk("R7 reset tx count", v, 0);
        bus_read(6'h14, v); chk("R8 reset intctl", v, 0);
        chk("R10 reset irq", {31'd0, irq}, 0);
        chk("R3 reset rx_ready", {31'd0, rx_ready}, 1);
        chk("R6 reset tx_valid", {31'd0, tx_valid}, 0);

        // R1 map
        bus_read(6'h00, v); chk("R1 id low", v, 32'h4D544B50);
        bus_read(6'h04, v); chk("R1 id high", v, 32'h31584F42);
        bus_read(6'h18, v); chk("R1 info", v, 32'h5);
        bus_write(6'h18, 32'hFFFF_FFFF);
        bus_read(6'h18, v); chk("R1 info write ignored", v, 32'h5);
        bus_read(6'h24, v); chk("R1 unmapped 0x24", v, 0);
        bus_read(6'h3C, v); chk("R1 unmapped 0x3C", v, 0);
        bus_read(6'h20, v); chk("R1 tx data reads 0", v, 0);

        // R2 busy during a receive frame
        for (int i = 0; i < 3; i++) frm[i] = 8'hA0 + 8'(i);
        rx_valid = 1'b1; rx_byte = frm[0]; rx_last = 1'b0;
        @(negedge clk);
        rx_valid = 1'b0;
        bus_read(6'h08, v); chk("R2 busy mid receive", v, 1);
        rx_send(1, 3);
        bus_read(6'h08, v); chk("R2 idle after receive", v, 0);
        chk("R3 rx_ready held off", {31'd0, rx_ready}, 0);
        bus_read(6'h14, v); chk("R8 rx flag", v, 32'h2);
        chk("R10 irq on rx", {31'd0, irq}, 1);
        drain_rx(3);
        chk("R3 still held while flag set", {31'd0, rx_ready}, 0);
        bus_write(6'h14, 32'h2);
        bus_read(6'h14, v); chk("R8 rx cleared", v, 0);
        chk("R10 irq low", {31'd0, irq}, 0);

        // R3 R4 R5 random receive frames, some longer than DEPTH
        for (int k = 0; k < 8; k++) begin
            len = (k == 0) ? 24 : 1 + int'($urandom % 24);
            for (int i = 0; i < len; i++) frm[i] = 8'($urandom);
            rx_send(0, len);
            if (len > DEPTH) chk("R5 saturate", 32'(min_depth(len)), 32'(DEPTH));
            drain_rx(min_depth(len));
            bus_write(6'h14, 32'h2);
        end

        // R6 R7 random transmit frames
        for (int k = 0; k < 6; k++) begin
            len = 1 + int'($urandom % DEPTH);
            bus_write(6'h10, 32'(len));
            bus_read(6'h10, v); chk("R6 tx count", v, 32'(len));
            for (int i = 0; i < len; i++) begin
                frm[i] = 8'($urandom);
                if (i == len - 1) chk("R6 no stream before full", {31'd0, tx_valid}, 0);
                bus_write(6'h20, {$urandom % 32'h0100_0000, frm[i]} );
            end
            chk("R6 stream starts", {31'd0, tx_valid}, 1);
            bus_write(6'h10, 32'd3);
            bus_read(6'h10, v); chk("R6 count write ignored while sending", v, 32'(len));
            bus_read(6'h08, v); chk("R2 busy while sending", v, 1);
            tx_collect(len);
            bus_read(6'h10, v); chk("R7 count cleared", v, 0);
            bus_read(6'h14, v); chk("R7 done flag", v, 32'h1);
            chk("R10 irq on tx", {31'd0, irq}, 1);
            bus_write(6'h20, 32'h55);
            chk("R6 extra write ignored", {31'd0, tx_valid}, 0);
            bus_read(6'h10, v); chk("R6 extra write count", v, 0);
            bus_write(6'h14, 32'h1);
        end

        // R6 clamp
        bus_write(6'h10, 32'd40);
        bus_read(6'h10, v); chk("R6 clamp", v, 32'(DEPTH));
        bus_write(6'h10, 32'd0);

        // R8 set wins over clear; R10 with both flags
        frm[0] = 8'h3C;
        bus_write(6'h10, 32'd1);
        bus_write(6'h20, 32'h3C);
        chk("R6 single byte last", {31'd0, tx_last}, 1);
        tx_ready = 1'b1; bus_wr = 1'b1; bus_addr = 6'h14; bus_wdata = 32'h1;
        @(negedge clk);
        tx_ready = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        bus_read(6'h14, v); chk("R8 set wins", v, 32'h1);
        frm[0] = 8'h77;
        rx_send(0, 1);
        bus_read(6'h14, v); chk("R8 both flags", v, 32'h3);
        bus_write(6'h14, 32'h2);
        bus_read(6'h14, v); chk("R8 clear only rx", v, 32'h1);
        chk("R10 irq from tx only", {31'd0, irq}, 1);
        bus_write(6'h14, 32'h1);
        chk("R10 irq low after clears", {31'd0, irq}, 0);
        drain_rx(1);

        // R9 test bit
        bus_write(6'h14, 32'h8000_0000);
        chk("R9 test irq", {31'd0, irq}, 1);
        bus_read(6'h14, v); chk("R9 read shows test", v, 32'h8000_0000);
        bus_read(6'h14, v); chk("R9 cleared by read", v, 0);
        chk("R10 irq after test read", {31'd0, irq}, 0);
        bus_write(6'h14, 32'h8000_0000);
        bus_write(6'h14, 32'h0);
        chk("R9 cleared by zero write", {31'd0, irq}, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule